// File: doc/BRIEF.md
# Key-Guarded Flash Program and Erase Controller

This block sits behind a simple 32-bit register bus and owns a small on-chip flash array model. It accepts page erase, per-bank mass erase and 64-bit double-word programming, but only after software has opened a lock by writing two magic words in a fixed order. Any wrong key closes that lock until the next reset. A second lock guards a single option word. It opens only while the main lock is already open, and only through its own pair of keys.

The bus offers five registers in the low half of the address space: main key at 0x00, option key at 0x04, status at 0x08, control at 0x0C and option word at 0x10. The flash window fills the upper half, with double-word i at byte offset 8*i. Every accepted operation keeps the busy flag high for a fixed number of cycles. The array changes on the last busy cycle, and an end flag is raised at that point. Faulty requests raise sticky error flags, which software clears by writing ones to them.

Top module: `fpec_ctrl`

## Requirements
- R1: After reset the control register reads 0xC000_0000 (bit 31 main locked, bit 30 option locked), status reads 0, busy is low, the array is all ones, and the committed option word equals OPT_INIT.
- R2: Writing 0x4567_0123 and then 0xCDEF_89AB to the key register (0x00) clears control bit 31. While bit 31 is set, control writes have no effect.
- R3: A wrong value or wrong order at a key register locks that lock permanently until reset. Later correct keys do not open it.
- R4: The option lock (control bit 30) opens after 0x0819_2A3B and then 0x4C5D_6E7F are written to 0x04 while the main lock is open. Option-key writes made while the main lock is closed are ignored. The option word at 0x10 accepts writes only while the option lock is open.
- R5: A control write with bit 31 set relocks both locks and clears the mode bits. A control write with bit 30 set relocks only the option lock. Afterwards the correct key pairs open the locks again.
- R6: Control bit 1 (page erase) together with bit 16 (start), the page number at bits 3 and up, and bank select at bit 11 sets every byte of that page to 0xFF. Status bit 16 (busy) is high for exactly BUSY_CYCLES cycles after the write. Status bit 0 (end) is then set.
- R7: Control bit 2 (bank 1 mass erase) and bit 15 (bank 2 mass erase) with start erase the chosen banks, either one or both.
- R8: With control bit 0 (program) set, a 32-bit write to the low word of a double-word followed by a write to its high word (+4) stores the 64-bit value after the busy time.
- R9: When the first program write targets a high word, status bit 5 (alignment) is set. When the second write is not the high word of the latched double-word, status bit 6 (size) is set. In both cases the array is unchanged.
- R10: Programming a double-word that is not all ones sets status bit 3 (program error) at once, starts no busy period, and leaves the data unchanged.
- R11: Status bit 7 (sequence) is set, and the array is unchanged, by: a flash write while busy, while locked, or with program clear; a start request while busy; a start that selects no erase or mixes page and mass erase.
- R12: Writing ones to status bits clears those bits, so writing back the value just read clears them all. The err output is high whenever status AND 0xC3FA is non-zero.
- R13: Control bit 17 with the option lock open commits the option word to opt_word when busy ends. Control bit 27 reads 1 for BUSY_CYCLES cycles and then clears itself. Either request with the option lock closed sets status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address; top bit selects the flash window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| busy | output | 1 | Operation in progress |
| eop | output | 1 | End-of-operation flag |
| err | output | 1 | Any masked error flag set |
| opt_word | output | 32 | Committed option word |

## Verification
The hardest states to reach from the ports are the ones that need an operation already running: a start or a flash write that lands inside the busy window, and a second program write that arrives after the first word was latched but to the wrong place. The bench reaches them by launching a page erase and then issuing the conflicting writes on the following cycles. It splits program writes across two addresses that differ by one double-word. A seeded random phase then mixes programs over blank and used double-words with page erases, so that repeated programming of used words and erases between them build up array states that no directed step would choose.

// File: rtl/fpec_pkg.sv
// Package: shared operation codes, magic keys and register bit positions
// for the key-guarded flash controller. Assumes a 32-bit register bus.
package fpec_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PAGE = 3'd1,
        OP_BANK = 3'd2,
        OP_PROG = 3'd3,
        OP_OPT  = 3'd4,
        OP_OBL  = 3'd5
    } fpec_op_e;

    localparam logic [31:0] KEY_MAIN_A = 32'h4567_0123;
    localparam logic [31:0] KEY_MAIN_B = 32'hCDEF_89AB;
    localparam logic [31:0] KEY_OPT_A  = 32'h0819_2A3B;
    localparam logic [31:0] KEY_OPT_B  = 32'h4C5D_6E7F;

    localparam int C_PG    = 0;
    localparam int C_PER   = 1;
    localparam int C_MER1  = 2;
    localparam int C_PNB   = 3;
    localparam int C_BKER  = 11;
    localparam int C_MER2  = 15;
    localparam int C_STRT  = 16;
    localparam int C_OSTRT = 17;
    localparam int C_OBL   = 27;
    localparam int C_OLOCK = 30;
    localparam int C_LOCK  = 31;

    localparam int S_EOP   = 0;
    localparam int S_PROG  = 3;
    localparam int S_ALIGN = 5;
    localparam int S_SIZE  = 6;
    localparam int S_SEQ   = 7;
    localparam int S_BUSY  = 16;

    localparam logic [15:0] ERR_MASK = 16'hC3FA;

endpackage

// File: rtl/fpec_keylock.sv
// Two-word key lock. Opens after KEY_A then KEY_B arrive while enabled.
// Any other value or order jams it shut until reset. Assumes key_wr is
// a single-cycle strobe; relock returns an unjammed lock to its start.
module fpec_keylock #(
    parameter logic [31:0] KEY_A = 32'h0,
    parameter logic [31:0] KEY_B = 32'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        relock,
    output logic        open
);

    typedef enum logic [1:0] {K_IDLE, K_HALF, K_OPEN, K_DEAD} kstate_e;
    kstate_e state_q;

    // Key sequence state machine with sticky jam state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= K_IDLE;
        end else if (relock && state_q != K_DEAD) begin
            state_q <= K_IDLE;
        end else if (key_wr && enable) begin
            case (state_q)
                K_IDLE:  state_q <= (key_data == KEY_A) ? K_HALF : K_DEAD;
                K_HALF:  state_q <= (key_data == KEY_B) ? K_OPEN : K_DEAD;
                default: state_q <= state_q;
            endcase
        end
    end

    assign open = (state_q == K_OPEN);

    // R3: a jammed lock never recovers before reset
    p_dead_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == K_DEAD |=> state_q == K_DEAD);

    // R2: the lock opens only on an enabled write of the second key
    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(key_wr && enable && key_data == KEY_B));

endmodule

// File: rtl/fpec_array.sv
// Flash array model: NUM_DW double-words split into two banks of PAGES
// pages. Applies one erase or program when apply pulses. Assumes the
// controller has already checked the request; reset leaves it erased.
module fpec_array
    import fpec_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int DW_PER_PAGE = 2,
    parameter int BANKS       = 2,
    localparam int NUM_DW     = BANKS * PAGES * DW_PER_PAGE,
    localparam int IDX_W      = $clog2(NUM_DW),
    localparam int PAGE_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  fpec_op_e          op,
    input  logic [PAGE_W-1:0] page,
    input  logic              bank,
    input  logic [BANKS-1:0]  bank_mask,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [63:0]       prog_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [63:0]       rd_data,
    input  logic [IDX_W-1:0]  chk_idx,
    output logic              chk_blank
);

    logic [63:0] mem [NUM_DW];

    function automatic int bank_of(int i);
        return i / (PAGES * DW_PER_PAGE);
    endfunction

    function automatic int page_of(int i);
        return (i / DW_PER_PAGE) % PAGES;
    endfunction

    // Storage update: erase the selected region or program one double-word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DW; i++) mem[i] <= '1;
        end else if (apply) begin
            for (int i = 0; i < NUM_DW; i++) begin
                case (op)
                    OP_PAGE: if (bank_of(i) == int'(bank) && page_of(i) == int'(page))
                                 mem[i] <= '1;
                    OP_BANK: if (bank_mask[bank_of(i)]) mem[i] <= '1;
                    OP_PROG: if (i == int'(prog_idx)) mem[i] <= prog_data;
                    default: ;
                endcase
            end
        end
    end

    assign rd_data   = mem[rd_idx];
    assign chk_blank = (mem[chk_idx] == '1);

    // R10: a program is only ever applied over an erased double-word
    p_prog_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_PROG) |-> (mem[prog_idx] == '1));

    // R11: without an apply pulse the storage holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(mem[0]) && $stable(mem[NUM_DW-1])));

endmodule

// File: rtl/fpec_ctrl.sv
// Key-guarded flash program/erase controller. Decodes a simple 32-bit
// register bus, gates control writes behind two key locks, checks program
// and erase requests, runs a fixed busy timer and drives the array model.
// Assumes bus_wr is a single-cycle strobe and reads are combinational.
module fpec_ctrl
    import fpec_pkg::*;
#(
    parameter int          PAGES       = 4,
    parameter int          DW_PER_PAGE = 2,
    parameter int          BUSY_CYCLES = 4,
    parameter logic [31:0] OPT_INIT    = 32'hFFFF_00AA,
    localparam int BANKS    = 2,
    localparam int NUM_DW   = BANKS * PAGES * DW_PER_PAGE,
    localparam int FLASH_AW = $clog2(NUM_DW * 8),
    localparam int ADDR_W   = FLASH_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              busy,
    output logic              eop,
    output logic              err,
    output logic [31:0]       opt_word
);

    localparam int IDX_W  = FLASH_AW - 3;
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
    localparam logic [FLASH_AW-1:0] OFF_KEY  = FLASH_AW'(0);
    localparam logic [FLASH_AW-1:0] OFF_OKEY = FLASH_AW'(4);
    localparam logic [FLASH_AW-1:0] OFF_STAT = FLASH_AW'(8);
    localparam logic [FLASH_AW-1:0] OFF_CTRL = FLASH_AW'(12);
    localparam logic [FLASH_AW-1:0] OFF_OPT  = FLASH_AW'(16);

    // ---- bus decode ----
    logic                in_flash;
    logic [FLASH_AW-1:0] off;
    logic                wr_key, wr_okey, wr_stat, wr_ctrl, wr_opt, wr_flash;

    assign in_flash = bus_addr[ADDR_W-1];
    assign off      = bus_addr[FLASH_AW-1:0];
    assign wr_key   = bus_wr && !in_flash && off == OFF_KEY;
    assign wr_okey  = bus_wr && !in_flash && off == OFF_OKEY;
    assign wr_stat  = bus_wr && !in_flash && off == OFF_STAT;
    assign wr_ctrl  = bus_wr && !in_flash && off == OFF_CTRL;
    assign wr_opt   = bus_wr && !in_flash && off == OFF_OPT;
    assign wr_flash = bus_wr && in_flash;

    // ---- state ----
    logic              pg_q, per_q, mer1_q, mer2_q, bker_q, obl_q;
    logic [PAGE_W-1:0] pnb_q;
    logic              st_eop, st_prog, st_align, st_size, st_seq;
    logic [CNT_W-1:0]  cnt_q;
    fpec_op_e          op_q;
    logic [PAGE_W-1:0] op_page;
    logic              op_bank;
    logic [1:0]        op_mask;
    logic [IDX_W-1:0]  op_idx, low_idx;
    logic [63:0]       op_data;
    logic [31:0]       low_q, opt_pend, opt_word_q;
    logic              have_low;
    logic              main_open, opt_open;
    logic              busy_w, finish;
    logic [63:0]       rd_dw;
    logic              chk_blank;

    assign busy_w = (cnt_q != '0);
    assign finish = (cnt_q == CNT_W'(1));

    // ---- control decode ----
    logic ctrl_ok, relock_main, relock_opt, cmd;
    logic w_strt, w_ostrt, w_obl, w_per, w_m1, w_m2, w_pg;
    logic go_page, go_bank, go_opt, go_obl, go_prog, cmd_bad, busy_start, launch;

    assign w_pg    = bus_wdata[C_PG];
    assign w_per   = bus_wdata[C_PER];
    assign w_m1    = bus_wdata[C_MER1];
    assign w_m2    = bus_wdata[C_MER2];
    assign w_strt  = bus_wdata[C_STRT];
    assign w_ostrt = bus_wdata[C_OSTRT];
    assign w_obl   = bus_wdata[C_OBL];

    assign ctrl_ok     = wr_ctrl && main_open && !busy_w;
    assign relock_main = ctrl_ok && bus_wdata[C_LOCK];
    assign relock_opt  = ctrl_ok && bus_wdata[C_OLOCK];
    assign cmd         = ctrl_ok && !bus_wdata[C_LOCK];
    assign go_page     = cmd && w_strt && w_per && !w_m1 && !w_m2 && !w_pg;
    assign go_bank     = cmd && w_strt && !w_per && (w_m1 || w_m2) && !w_pg;
    assign go_opt      = cmd && !w_strt && w_ostrt && opt_open;
    assign go_obl      = cmd && !w_strt && !w_ostrt && w_obl && opt_open;
    assign cmd_bad     = cmd && ((w_strt && !go_page && !go_bank) ||
                                 (!w_strt && w_ostrt && !opt_open) ||
                                 (!w_strt && !w_ostrt && w_obl && !opt_open));
    assign busy_start  = wr_ctrl && main_open && busy_w && (w_strt || w_ostrt || w_obl);

    // ---- program path decode ----
    logic             fl_ok, fl_bad, fl_hi, fl_align, fl_latch, fl_size, fl_match, fl_nonblank;
    logic [IDX_W-1:0] fl_idx;

    assign fl_idx      = off[FLASH_AW-1:3];
    assign fl_hi       = off[2];
    assign fl_ok       = wr_flash && main_open && pg_q && !busy_w;
    assign fl_bad      = wr_flash && !fl_ok;
    assign fl_align    = fl_ok && !have_low && fl_hi;
    assign fl_latch    = fl_ok && !have_low && !fl_hi;
    assign fl_match    = fl_hi && (fl_idx == low_idx);
    assign fl_size     = fl_ok && have_low && !fl_match;
    assign fl_nonblank = fl_ok && have_low && fl_match && !chk_blank;
    assign go_prog     = fl_ok && have_low && fl_match && chk_blank;
    assign launch      = go_page || go_bank || go_opt || go_obl || go_prog;

    // ---- locks ----
    fpec_keylock #(.KEY_A(KEY_MAIN_A), .KEY_B(KEY_MAIN_B)) u_main_lock (
        .clk(clk), .rst_n(rst_n), .enable(1'b1), .key_wr(wr_key),
        .key_data(bus_wdata), .relock(relock_main), .open(main_open)
    );

    fpec_keylock #(.KEY_A(KEY_OPT_A), .KEY_B(KEY_OPT_B)) u_opt_lock (
        .clk(clk), .rst_n(rst_n), .enable(main_open), .key_wr(wr_okey),
        .key_data(bus_wdata), .relock(relock_main || relock_opt), .open(opt_open)
    );

    // Mode bits of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n || relock_main) begin
            {pg_q, per_q, mer1_q, mer2_q, bker_q} <= '0;
            pnb_q <= '0;
        end else if (cmd) begin
            pg_q   <= w_pg;
            per_q  <= w_per;
            mer1_q <= w_m1;
            mer2_q <= w_m2;
            bker_q <= bus_wdata[C_BKER];
            pnb_q  <= bus_wdata[C_PNB +: PAGE_W];
        end
    end

    // Low-word latch for the two-write double-word program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_low <= 1'b0;
            low_q    <= '0;
            low_idx  <= '0;
        end else if (cmd || relock_main) begin
            have_low <= 1'b0;
        end else if (fl_latch) begin
            have_low <= 1'b1;
            low_q    <= bus_wdata;
            low_idx  <= fl_idx;
        end else if (fl_ok) begin
            have_low <= 1'b0;
        end
    end

    // Busy timer and captured operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            op_q    <= OP_NONE;
            op_page <= '0;
            op_bank <= 1'b0;
            op_mask <= '0;
            op_idx  <= '0;
            op_data <= '0;
        end else if (launch) begin
            cnt_q   <= CNT_W'(BUSY_CYCLES);
            op_q    <= go_page ? OP_PAGE : go_bank ? OP_BANK : go_opt ? OP_OPT :
                       go_obl ? OP_OBL : OP_PROG;
            op_page <= bus_wdata[C_PNB +: PAGE_W];
            op_bank <= bus_wdata[C_BKER];
            op_mask <= {w_m2, w_m1};
            op_idx  <= low_idx;
            op_data <= {bus_wdata, low_q};
        end else if (busy_w) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Option word staging, commit and load-launch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_pend   <= OPT_INIT;
            opt_word_q <= OPT_INIT;
            obl_q      <= 1'b0;
        end else begin
            if (wr_opt && opt_open && !busy_w) opt_pend <= bus_wdata;
            if (finish && op_q == OP_OPT) opt_word_q <= opt_pend;
            if (go_obl) obl_q <= 1'b1;
            else if (finish && op_q == OP_OBL) obl_q <= 1'b0;
        end
    end

    // Sticky status flags: write-one-to-clear, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {st_eop, st_prog, st_align, st_size, st_seq} <= '0;
        end else begin
            if (wr_stat) begin
                if (bus_wdata[S_EOP])   st_eop   <= 1'b0;
                if (bus_wdata[S_PROG])  st_prog  <= 1'b0;
                if (bus_wdata[S_ALIGN]) st_align <= 1'b0;
                if (bus_wdata[S_SIZE])  st_size  <= 1'b0;
                if (bus_wdata[S_SEQ])   st_seq   <= 1'b0;
            end
            if (finish && op_q != OP_OBL)            st_eop   <= 1'b1;
            if (fl_nonblank)                         st_prog  <= 1'b1;
            if (fl_align)                            st_align <= 1'b1;
            if (fl_size)                             st_size  <= 1'b1;
            if (cmd_bad || busy_start || fl_bad)     st_seq   <= 1'b1;
        end
    end

    // ---- array ----
    fpec_array #(.PAGES(PAGES), .DW_PER_PAGE(DW_PER_PAGE), .BANKS(BANKS)) u_array (
        .clk(clk), .rst_n(rst_n), .apply(finish), .op(op_q), .page(op_page),
        .bank(op_bank), .bank_mask(op_mask), .prog_idx(op_idx), .prog_data(op_data),
        .rd_idx(fl_idx), .rd_data(rd_dw), .chk_idx(low_idx), .chk_blank(chk_blank)
    );

    // ---- read mux and outputs ----
    logic [31:0] stat_word, ctrl_word;

    // Assemble the status word from the flags.
    always_comb begin
        stat_word          = '0;
        stat_word[S_EOP]   = st_eop;
        stat_word[S_PROG]  = st_prog;
        stat_word[S_ALIGN] = st_align;
        stat_word[S_SIZE]  = st_size;
        stat_word[S_SEQ]   = st_seq;
        stat_word[S_BUSY]  = busy_w;
    end

    // Assemble the control word from the mode bits and locks.
    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[C_PG]            = pg_q;
        ctrl_word[C_PER]           = per_q;
        ctrl_word[C_MER1]          = mer1_q;
        ctrl_word[C_PNB +: PAGE_W] = pnb_q;
        ctrl_word[C_BKER]          = bker_q;
        ctrl_word[C_MER2]          = mer2_q;
        ctrl_word[C_OBL]           = obl_q;
        ctrl_word[C_OLOCK]         = !opt_open;
        ctrl_word[C_LOCK]          = !main_open;
    end

    // Select read data by address.
    always_comb begin
        if (in_flash)              bus_rdata = fl_hi ? rd_dw[63:32] : rd_dw[31:0];
        else if (off == OFF_STAT)  bus_rdata = stat_word;
        else if (off == OFF_CTRL)  bus_rdata = ctrl_word;
        else if (off == OFF_OPT)   bus_rdata = opt_pend;
        else                       bus_rdata = '0;
    end

    assign busy     = busy_w;
    assign eop      = st_eop;
    assign err      = |(stat_word[15:0] & ERR_MASK);
    assign opt_word = opt_word_q;

    // R6: the timer never exceeds its load value
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUSY_CYCLES));

    // R6: a finishing array operation raises the end flag and drops busy
    p_eop_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && op_q != OP_OBL) |=> (st_eop && !busy_w));

    // R2: control writes while locked leave the mode bits untouched
    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !main_open) |=> $stable({pg_q, per_q, mer1_q, mer2_q, bker_q, pnb_q}));

    // R11: a flash write during busy raises the sequence flag
    p_flash_busy_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flash && busy_w) |=> st_seq);

    // R13: the load-launch bit only falls when its own timer ends
    p_obl_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obl_q) |-> !busy_w);

endmodule

// File: tb/test_fpec_ctrl.sv
module test_fpec_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 4;
    localparam int NDW        = 16;
    localparam logic [31:0] OPT_INIT = 32'hFFFF_00AA;
    localparam logic [7:0] A_KEY = 8'h00, A_OKEY = 8'h04, A_STAT = 8'h08,
                           A_CTRL = 8'h0C, A_OPT = 8'h10;

    logic        clk = 0, rst_n = 0, bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata, opt_word;
    logic        busy, eop, err;
    logic [63:0] model [NDW];
    int vectors = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpec_ctrl #(.PAGES(4), .DW_PER_PAGE(2), .BUSY_CYCLES(BUSY), .OPT_INIT(OPT_INIT)) i_fpec_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .eop(eop),
        .err(err), .opt_word(opt_word));

    function automatic logic [7:0] dw_addr(int i);
        return 8'h80 + 8'(i * 8);
    endfunction
    function automatic logic [31:0] erase_cmd(int bk, int pg);
        return 32'h0001_0002 | (32'(pg) << 3) | (32'(bk) << 11);
    endfunction
    function automatic logic [31:0] mass_cmd(bit b1, bit b2);
        return 32'h0001_0000 | (32'(b1) << 2) | (32'(b2) << 15);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NDW; i++) model[i] = '1;
    endtask

    task automatic unlock_main();
        wr(A_KEY, 32'h4567_0123);
        wr(A_KEY, 32'hCDEF_89AB);
    endtask

    task automatic clr_stat();
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic check_array(string tag);
        logic [31:0] lo, hi;
        for (int i = 0; i < NDW; i++) begin
            rd(dw_addr(i), lo);
            rd(dw_addr(i) + 8'd4, hi);
            check(tag, lo, model[i][31:0]);
            check(tag, hi, model[i][63:32]);
        end
    endtask

    // Program one double-word (PG must already be set); checks per R8/R10.
    task automatic do_prog(int idx, logic [63:0] d);
        clr_stat();
        wr(dw_addr(idx), d[31:0]);
        wr(dw_addr(idx) + 8'd4, d[63:32]);
        if (model[idx] == '1) begin
            chk_reg("R8 busy", A_STAT, 32'h0001_0000);
            repeat (BUSY) @(negedge clk);
            chk_reg("R8 eop", A_STAT, 32'h0000_0001);
            model[idx] = d;
        end else begin
            chk_reg("R10 progerr", A_STAT, 32'h0000_0008);
        end
    endtask

    // Page erase with busy-length check (R6).
    task automatic do_page_erase(int bk, int pg);
        clr_stat();
        wr(A_CTRL, erase_cmd(bk, pg));
        check("R6 busy start", 32'(busy), 32'd1);
        repeat (BUSY - 1) @(negedge clk);
        chk_reg("R6 busy last", A_STAT, 32'h0001_0000);
        @(negedge clk);
        chk_reg("R6 eop", A_STAT, 32'h0000_0001);
        for (int j = 0; j < 2; j++) model[bk * 8 + pg * 2 + j] = '1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        do_reset();

        // R1 reset state
        chk_reg("R1 ctrl", A_CTRL, 32'hC000_0000);
        chk_reg("R1 status", A_STAT, 32'h0);
        check("R1 busy", 32'(busy), 0);
        check("R1 opt_word", opt_word, OPT_INIT);
        check_array("R1 array");

        // R2 control writes ignored while locked
        wr(A_CTRL, 32'h0000_0001);
        chk_reg("R2 locked ctrl", A_CTRL, 32'hC000_0000);
        // R11 flash write while locked
        wr(dw_addr(0), 32'h1234_5678);
        chk_reg("R11 locked flash seq", A_STAT, 32'h0000_0080);
        check("R12 err on", 32'(err), 1);
        rd(A_STAT, d);
        wr(A_STAT, d);
        chk_reg("R12 writeback clear", A_STAT, 32'h0);
        check("R12 err off", 32'(err), 0);
        // R4 option key while main locked ignored
        wr(A_OKEY, 32'h0819_2A3B);
        wr(A_OKEY, 32'h4C5D_6E7F);
        unlock_main();
        chk_reg("R2 unlocked", A_CTRL, 32'h4000_0000);
        chk_reg("R4 opt still locked", A_CTRL, 32'h4000_0000);
        wr(A_OPT, 32'h0000_1234);
        chk_reg("R4 opt write ignored", A_OPT, OPT_INIT);

        // R8 program
        wr(A_CTRL, 32'h0000_0001);
        do_prog(0, 64'hDEAD_BEEF_0BAD_F00D);
        check_array("R8 array");
        // R9 alignment
        clr_stat();
        wr(dw_addr(1) + 8'd4, 32'h1111_1111);
        chk_reg("R9 align", A_STAT, 32'h0000_0020);
        // R9 size
        clr_stat();
        wr(dw_addr(2), 32'h2222_2222);
        wr(dw_addr(3) + 8'd4, 32'h3333_3333);
        chk_reg("R9 size", A_STAT, 32'h0000_0040);
        check("R12 err size", 32'(err), 1);
        // R10 reprogram non-blank
        do_prog(0, 64'h0);
        check_array("R10 unchanged");

        // R11 requests during busy
        do_page_erase(0, 0);
        clr_stat();
        wr(A_CTRL, erase_cmd(1, 3));
        wr(dw_addr(5), 32'h5555_5555);
        wr(A_CTRL, mass_cmd(1, 1));
        repeat (BUSY) @(negedge clk);
        chk_reg("R11 busy seq", A_STAT, 32'h0000_0081);
        chk_reg("R11 ctrl kept", A_CTRL, 32'h4000_0000 | (erase_cmd(1, 3) & 32'hFFFE_FFFF));
        check_array("R11 array");
        // R11 flash write with PG clear
        clr_stat();
        wr(dw_addr(4), 32'h4444_4444);
        chk_reg("R11 pg clear", A_STAT, 32'h0000_0080);
        // R11 mixed start
        clr_stat();
        wr(A_CTRL, 32'h0001_0006);
        chk_reg("R11 bad start", A_STAT, 32'h0000_0080);
        check("R11 no busy", 32'(busy), 0);

        // random mix of programs and page erases (R6, R8, R10)
        for (int k = 0; k < 60; k++) begin
            if (k % 7 == 6) begin
                do_page_erase(int'($urandom % 2), int'($urandom % 4));
            end else begin
                wr(A_CTRL, 32'h0000_0001);
                do_prog(int'($urandom % NDW), {$urandom, $urandom});
            end
        end
        check_array("R8 random array");

        // R7 mass erase bank 1 only, then both
        clr_stat();
        wr(A_CTRL, mass_cmd(1, 0));
        repeat (BUSY) @(negedge clk);
        chk_reg("R7 eop", A_STAT, 32'h1);
        for (int i = 0; i < 8; i++) model[i] = '1;
        check_array("R7 bank1");
        wr(A_CTRL, 32'h0000_0001);
        do_prog(3, 64'h0123_4567_89AB_CDEF);
        clr_stat();
        wr(A_CTRL, mass_cmd(1, 1));
        repeat (BUSY) @(negedge clk);
        for (int i = 0; i < NDW; i++) model[i] = '1;
        check_array("R7 both");

        // R13 option start/launch while option locked
        clr_stat();
        wr(A_CTRL, 32'h0002_0000);
        chk_reg("R13 locked ostrt", A_STAT, 32'h0000_0080);
        // R4 option unlock and option word
        wr(A_OKEY, 32'h0819_2A3B);
        wr(A_OKEY, 32'h4C5D_6E7F);
        chk_reg("R4 opt open", A_CTRL, 32'h0);
        wr(A_OPT, 32'hA5A5_5A5A);
        chk_reg("R4 opt staged", A_OPT, 32'hA5A5_5A5A);
        clr_stat();
        wr(A_CTRL, 32'h0002_0000);
        check("R13 opt busy", 32'(busy), 1);
        check("R13 opt pre", opt_word, OPT_INIT);
        repeat (BUSY) @(negedge clk);
        check("R13 opt commit", opt_word, 32'hA5A5_5A5A);
        wr(A_CTRL, 32'h0800_0000);
        chk_reg("R13 obl set", A_CTRL, 32'h0800_0000);
        repeat (BUSY - 1) @(negedge clk);
        chk_reg("R13 obl held", A_CTRL, 32'h0800_0000);
        @(negedge clk);
        chk_reg("R13 obl clear", A_CTRL, 32'h0);

        // R5 relock option, then both, then reopen
        wr(A_CTRL, 32'h4000_0000);
        chk_reg("R5 opt relock", A_CTRL, 32'h4000_0000);
        wr(A_CTRL, 32'h8000_0000);
        chk_reg("R5 main relock", A_CTRL, 32'hC000_0000);
        wr(A_CTRL, 32'h0000_0001);
        chk_reg("R5 relocked ignore", A_CTRL, 32'hC000_0000);
        unlock_main();
        chk_reg("R5 reopen", A_CTRL, 32'h4000_0000);

        // R3 option lock jam, then main lock jam
        wr(A_OKEY, 32'h4C5D_6E7F);
        wr(A_OKEY, 32'h0819_2A3B);
        wr(A_OKEY, 32'h4C5D_6E7F);
        chk_reg("R3 opt jammed", A_CTRL, 32'h4000_0000);
        do_reset();
        wr(A_KEY, 32'hCDEF_89AB);
        unlock_main();
        chk_reg("R3 main jammed", A_CTRL, 32'hC000_0000);
        do_reset();
        wr(A_KEY, 32'h4567_0123);
        wr(A_KEY, 32'h0000_0000);
        unlock_main();
        chk_reg("R3 wrong second", A_CTRL, 32'hC000_0000);
        do_reset();
        unlock_main();
        chk_reg("R3 reset recovers", A_CTRL, 32'h4000_0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule